// File: doc/BRIEF.md
# Audio Receive Word Buffer with Event Flags

This block stores 32-bit audio words handed over by a serial audio receiver and lets a bus-side reader take them out one word at a time, oldest first. It keeps an occupancy count (exported in bytes, four per word) and watches for four conditions: a programmed fill level has been reached, a read was attempted while nothing was stored, the enabled receiver has gone quiet for too long, and a programmed number of bytes has arrived since the receiver was last started.

Each condition latches into a raw flag at a fixed bit position. A per-bit enable mask forms the status vector, and the OR of the status bits drives a single interrupt line. Software acknowledges a flag by writing a one to the matching clear bit. Three synchronous single-cycle controls reset the read/write pointers, zero the stored words, or restart the receive-side counters.

Top module: `rx_word_buffer`

## Requirements
- R1: After reset the buffer is empty, `fillBytes` is 0, `irqRaw` and `irqStatus` are 0, `irqLine` is low and `rdData` is 0.
- R2: Words accepted from the receiver come out in arrival order. A cycle with `rdReq` high on a non-empty buffer loads the oldest word into `rdData` at that clock edge. `fillBytes` always equals the stored word count times 4.
- R3: The buffer holds at most DEPTH words (default 256, so 1024 bytes). A word offered while full is dropped, and the stored words stay unchanged.
- R4: `rdReq` while empty sets raw bit 2 (underflow) at that edge, and leaves `rdData` and `fillBytes` unchanged.
- R5: With a nonzero `thresholdWords`, raw bit 5 is set on every clock edge at which the registered occupancy is at or above the threshold. This is one edge after the occupancy first gets there. A threshold of 0 disables the flag.
- R6: Every accepted word adds 4 to a byte counter. When the sum reaches or passes a nonzero `doneBytes`, raw bit 0 is set at that edge and the counter restarts from 0. The counter also restarts when `rxEnable` rises. A `doneBytes` of 0 disables the flag.
- R7: While `rxEnable` is high and `rxValid` stays low, an idle counter counts clock edges. Raw bit 1 is set at the edge where it reaches a nonzero `hangLimit`. It fires only once per idle stretch, and a delivered word or a low `rxEnable` ends the stretch.
- R8: The raw flags sit at bits 0 (done), 1 (hung), 2 (underflow) and 5 (threshold), and bits 3 and 4 read as 0. `irqStatus` is `irqRaw` AND `irqEnable`, and `irqLine` is the OR of `irqStatus`. A one in `irqClear` clears that raw bit, a zero leaves it alone, and a new event in the same cycle wins over the clear.
- R9: `ptrReset` empties the buffer at the next edge. `memReset` zeroes every stored word but keeps the pointers and the count.
- R10: `rxReset` restarts the byte counter and the idle counter without touching the buffer contents.
- R11: While `rxEnable` is low, offered words are neither stored nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver started/enabled level |
| rxValid | input | 1 | Receiver offers a word this cycle |
| rxData | input | 32 | Offered word |
| rdReq | input | 1 | Bus-side pop request |
| rdData | output | 32 | Last popped word |
| fillBytes | output | 11 | Occupancy in bytes |
| thresholdWords | input | 9 | Fill-level threshold in words, 0 disables |
| doneBytes | input | 16 | Byte count for the done flag, 0 disables |
| hangLimit | input | 16 | Idle cycles before the hung flag, 0 disables |
| ptrReset | input | 1 | Synchronous pointer/count reset pulse |
| memReset | input | 1 | Synchronous storage clear pulse |
| rxReset | input | 1 | Synchronous receive-counter reset pulse |
| irqEnable | input | 6 | Per-flag enable mask |
| irqClear | input | 6 | Write-one-to-clear strobes |
| irqRaw | output | 6 | Raw event flags |
| irqStatus | output | 6 | Masked flags |
| irqLine | output | 1 | OR of masked flags |

## Verification
The bench fills the buffer past its wrap point and then offers one more word. A design that let that word through would show 1028 bytes or corrupt the oldest entry. It checks that a threshold flag cleared while the level is still high comes straight back, and that the hung flag does not fire again after acknowledgement during the same idle stretch; designs that treat clear as dominant or count a sticky idle as new events fail these. It also pops an empty buffer and expects `rdData` to hold its old value. After `memReset` it expects zeroed data but an unchanged fill. After `rxReset` mid-frame it expects the done flag to wait for a full new byte count.

// File: rtl/rx_word_buffer_pkg.sv
package rx_word_buffer_pkg;
  localparam int IRQ_W     = 6;
  localparam int BIT_DONE  = 0;
  localparam int BIT_HUNG  = 1;
  localparam int BIT_UNDER = 2;
  localparam int BIT_THR   = 5;
  localparam logic [IRQ_W-1:0] IRQ_USED = 6'b100111;

  typedef struct packed {
    logic push;
    logic pop;
    logic ptrClear;
    logic memClear;
  } fifo_cmd_t;
endpackage

// File: rtl/rx_word_datapath.sv
module rx_word_datapath
  import rx_word_buffer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_cmd_t         cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  fillWords,
  output logic              isFull,
  output logic              isEmpty
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign isFull  = (fillWords == DEPTH_C);
  assign isEmpty = (fillWords == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (cmd.memClear) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (cmd.push) begin
      store[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillWords <= '0;
    end else if (cmd.ptrClear) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillWords <= '0;
    end else begin
      if (cmd.push) wrPtr <= advance(wrPtr);
      if (cmd.pop)  rdPtr <= advance(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   fillWords <= fillWords + 1'b1;
        2'b01:   fillWords <= fillWords - 1'b1;
        default: fillWords <= fillWords;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (cmd.pop) rdData <= store[rdPtr];
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillWords <= DEPTH_C);
  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !cmd.push);
  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !cmd.pop);
  a_r9_ptr_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ptrClear |=> (fillWords == '0));
  a_r9_mem_clear_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.memClear && !cmd.ptrClear && !cmd.push && !cmd.pop) |=> $stable(fillWords));
endmodule

// File: rtl/rx_word_control.sv
module rx_word_control
  import rx_word_buffer_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int BYTE_W = 16,
  parameter int HANG_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             rxValid,
  input  logic             rdReq,
  input  logic             ptrReset,
  input  logic             memReset,
  input  logic             rxReset,
  input  logic [CNT_W-1:0] thresholdWords,
  input  logic [BYTE_W-1:0] doneBytes,
  input  logic [HANG_W-1:0] hangLimit,
  input  logic [IRQ_W-1:0] irqEnable,
  input  logic [IRQ_W-1:0] irqClear,
  input  logic [CNT_W-1:0] fillWords,
  input  logic             isFull,
  input  logic             isEmpty,
  output fifo_cmd_t        cmd,
  output logic [IRQ_W-1:0] irqRaw,
  output logic [IRQ_W-1:0] irqStatus,
  output logic             irqLine
);
  logic              rxEnPrev;
  logic [BYTE_W-1:0] byteCnt;
  logic [HANG_W-1:0] idleCnt;
  logic              startEv, doneEv, hungEv, underEv, thrEv;
  logic [BYTE_W-1:0] byteBase;
  logic [BYTE_W:0]   byteSum;
  logic              idleRun, idleStep;
  logic [IRQ_W-1:0]  evVec;

  always_comb begin
    cmd          = '0;
    cmd.push     = rxValid && rxEnable && !isFull && !ptrReset;
    cmd.pop      = rdReq && !isEmpty && !ptrReset;
    cmd.ptrClear = ptrReset;
    cmd.memClear = memReset;
  end

  assign startEv  = rxEnable && !rxEnPrev;
  assign underEv  = rdReq && isEmpty;
  assign thrEv    = (thresholdWords != '0) && (fillWords >= thresholdWords);

  assign byteBase = (rxReset || startEv) ? '0 : byteCnt;
  assign byteSum  = {1'b0, byteBase} + (BYTE_W + 1)'(4);
  assign doneEv   = cmd.push && (doneBytes != '0) && (byteSum >= {1'b0, doneBytes});

  assign idleRun  = rxEnable && !rxValid && !rxReset;
  assign idleStep = idleRun && (idleCnt != hangLimit);
  assign hungEv   = idleStep && (hangLimit != '0) && ((idleCnt + 1'b1) == hangLimit);

  always_comb begin
    evVec            = '0;
    evVec[BIT_DONE]  = doneEv;
    evVec[BIT_HUNG]  = hungEv;
    evVec[BIT_UNDER] = underEv;
    evVec[BIT_THR]   = thrEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnPrev <= 1'b0;
      byteCnt  <= '0;
      idleCnt  <= '0;
      irqRaw   <= '0;
    end else begin
      rxEnPrev <= rxEnable;
      if (doneEv)        byteCnt <= '0;
      else if (cmd.push) byteCnt <= byteSum[BYTE_W-1:0];
      else               byteCnt <= byteBase;
      if (!idleRun)      idleCnt <= '0;
      else if (idleStep) idleCnt <= idleCnt + 1'b1;
      irqRaw <= ((irqRaw & ~irqClear) | evVec) & IRQ_USED;
    end
  end

  assign irqStatus = irqRaw & irqEnable;
  assign irqLine   = |irqStatus;

  a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && isEmpty) |=> irqRaw[BIT_UNDER]);
  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear[BIT_DONE] && !doneEv) |=> !irqRaw[BIT_DONE]);
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (irqRaw[4:3] == 2'b00));
  a_r11_disabled_no_push: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> !cmd.push);
  a_r7_hung_only_when_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !irqRaw[BIT_HUNG]) |=> !irqRaw[BIT_HUNG] || $past(irqClear[BIT_HUNG]) == 1'b0);
endmodule

// File: rtl/rx_word_buffer.sv
module rx_word_buffer
  import rx_word_buffer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int BYTE_W = 16,
  parameter int HANG_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W+1:0]  fillBytes,
  input  logic [CNT_W-1:0]  thresholdWords,
  input  logic [BYTE_W-1:0] doneBytes,
  input  logic [HANG_W-1:0] hangLimit,
  input  logic              ptrReset,
  input  logic              memReset,
  input  logic              rxReset,
  input  logic [IRQ_W-1:0]  irqEnable,
  input  logic [IRQ_W-1:0]  irqClear,
  output logic [IRQ_W-1:0]  irqRaw,
  output logic [IRQ_W-1:0]  irqStatus,
  output logic              irqLine
);
  fifo_cmd_t        cmd;
  logic [CNT_W-1:0] fillWords;
  logic             isFull, isEmpty;

  rx_word_control #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .HANG_W(HANG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rxValid(rxValid), .rdReq(rdReq),
    .ptrReset(ptrReset), .memReset(memReset), .rxReset(rxReset),
    .thresholdWords(thresholdWords), .doneBytes(doneBytes), .hangLimit(hangLimit),
    .irqEnable(irqEnable), .irqClear(irqClear), .fillWords(fillWords),
    .isFull(isFull), .isEmpty(isEmpty), .cmd(cmd),
    .irqRaw(irqRaw), .irqStatus(irqStatus), .irqLine(irqLine)
  );

  rx_word_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(rxData), .rdData(rdData),
    .fillWords(fillWords), .isFull(isFull), .isEmpty(isEmpty)
  );

  assign fillBytes = {fillWords, 2'b00};
endmodule

// File: tb/tb_rx_word_buffer.sv
module tb_rx_word_buffer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rstN = 0;
  logic        rxEnable = 0, rxValid = 0, rdReq = 0;
  logic [31:0] rxData = 0;
  logic [31:0] rdData;
  logic [10:0] fillBytes;
  logic [8:0]  thresholdWords = 0;
  logic [15:0] doneBytes = 0, hangLimit = 0;
  logic        ptrReset = 0, memReset = 0, rxReset = 0;
  logic [5:0]  irqEnable = 0, irqClear = 0;
  logic [5:0]  irqRaw, irqStatus;
  logic        irqLine;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_word_buffer dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rxValid(rxValid), .rxData(rxData),
    .rdReq(rdReq), .rdData(rdData), .fillBytes(fillBytes), .thresholdWords(thresholdWords),
    .doneBytes(doneBytes), .hangLimit(hangLimit), .ptrReset(ptrReset), .memReset(memReset),
    .rxReset(rxReset), .irqEnable(irqEnable), .irqClear(irqClear), .irqRaw(irqRaw),
    .irqStatus(irqStatus), .irqLine(irqLine)
  );

  typedef struct packed {
    logic        isPop;
    logic [31:0] data;
    logic [10:0] expFill;
    logic [31:0] expRd;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 32'h0000_0011, 11'd4,  32'h0},
    '{1'b0, 32'h0000_0022, 11'd8,  32'h0},
    '{1'b0, 32'h0000_0033, 11'd12, 32'h0},
    '{1'b1, 32'h0,         11'd8,  32'h0000_0011},
    '{1'b0, 32'h0000_0044, 11'd12, 32'h0},
    '{1'b1, 32'h0,         11'd8,  32'h0000_0022},
    '{1'b1, 32'h0,         11'd4,  32'h0000_0033},
    '{1'b1, 32'h0,         11'd0,  32'h0000_0044}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushWord(input logic [31:0] d);
    rxValid = 1; rxData = d;
    tick();
    rxValid = 0;
  endtask

  task automatic popWord();
    rdReq = 1;
    tick();
    rdReq = 0;
  endtask

  task automatic clearAll();
    irqClear = 6'h3f;
    tick();
    irqClear = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    rxEnable = 1;
    tick();
    // R1 reset state
    check("R1 fill", fillBytes, 0);
    check("R1 raw", irqRaw, 0);
    check("R1 line/status", {irqStatus, irqLine}, 0);
    check("R1 rdData", rdData, 0);

    // R2 table of pushes and pops
    foreach (VECS[i]) begin
      if (VECS[i].isPop) popWord(); else pushWord(VECS[i].data);
      check("R2 fill", fillBytes, VECS[i].expFill);
      if (VECS[i].isPop) check("R2 order", rdData, VECS[i].expRd);
    end

    // R4 underflow
    popWord();
    check("R4 underflow raw", irqRaw, 6'b000100);
    check("R4 rdData held", rdData, 32'h44);
    check("R4 fill held", fillBytes, 0);

    // R8 mask, line, clear
    irqEnable = 6'b000100;
    #1;
    check("R8 status", irqStatus, 6'b000100);
    check("R8 line", irqLine, 1);
    irqClear = 6'b000001; tick(); irqClear = 0;
    check("R8 zero clear ignored", irqRaw, 6'b000100);
    irqEnable = 0;
    #1;
    check("R8 line masked", irqLine, 0);
    irqClear = 6'b000100; tick(); irqClear = 0;
    check("R8 w1c", irqRaw, 0);

    // R5 threshold
    thresholdWords = 3;
    pushWord(1); pushWord(2);
    check("R5 below", irqRaw[5], 0);
    pushWord(3);
    check("R5 latency", irqRaw[5], 0);
    tick();
    check("R5 set", irqRaw[5], 1);
    irqClear = 6'b100000; tick(); irqClear = 0;
    check("R5 set beats clear", irqRaw[5], 1);
    popWord();
    irqClear = 6'b100000; tick(); irqClear = 0;
    check("R5 cleared below", irqRaw[5], 0);
    popWord(); popWord();
    thresholdWords = 0;

    // R3 fill to full through pointer wrap, drop extra
    for (int i = 0; i < 256; i++) pushWord(32'h1000 + i);
    check("R3 full fill", fillBytes, 1024);
    pushWord(32'hDEAD);
    check("R3 drop when full", fillBytes, 1024);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
        popWord();
        if (rdData !== 32'h1000 + i) bad++;
      end
      check("R3 stored data intact", bad, 0);
    end
    check("R3 drained", fillBytes, 0);
    clearAll();

    // R9 memory clear and pointer clear
    pushWord(32'hAAAA); pushWord(32'hBBBB);
    memReset = 1; tick(); memReset = 0;
    check("R9 memReset keeps fill", fillBytes, 8);
    popWord();
    check("R9 memReset zeroes", rdData, 0);
    ptrReset = 1; tick(); ptrReset = 0;
    check("R9 ptrReset empties", fillBytes, 0);

    // R11 receiver disabled
    rxEnable = 0;
    pushWord(32'h5555);
    check("R11 ignored", fillBytes, 0);

    // R6 done after byte count, restart on enable
    doneBytes = 12;
    tick();
    rxEnable = 1;
    tick();
    clearAll();
    pushWord(1); pushWord(2);
    check("R6 not yet", irqRaw[0], 0);
    pushWord(3);
    check("R6 done", irqRaw[0], 1);
    clearAll();

    // R10 rxReset restarts byte count
    pushWord(4); pushWord(5);
    rxReset = 1; tick(); rxReset = 0;
    check("R10 fifo kept", fillBytes, 20);
    pushWord(6); pushWord(7);
    check("R10 count restarted", irqRaw[0], 0);
    pushWord(8);
    check("R10 done after restart", irqRaw[0], 1);
    doneBytes = 0;
    ptrReset = 1; tick(); ptrReset = 0;
    clearAll();

    // R7 hung receiver
    rxEnable = 0;
    hangLimit = 5;
    tick();
    clearAll();
    rxEnable = 1;
    repeat (4) tick();
    check("R7 before limit", irqRaw[1], 0);
    tick();
    check("R7 at limit", irqRaw[1], 1);
    irqClear = 6'b000010; tick(); irqClear = 0;
    repeat (3) tick();
    check("R7 once per stretch", irqRaw[1], 0);

    summary();
  end
endmodule